// File: doc/BRIEF.md
# Serial Port with Fractional Rate Divider

This block is a full-duplex asynchronous serial port that sends and receives frames of eight data bits, one stop bit and no parity. A 16x oversampling tick is derived from the system clock by a divider with a 16-bit whole part and a 6-bit fraction in units of 1/64. The fraction is spread over successive tick periods by a small accumulator, so the long-run tick rate is exact even when the clock is not an integer multiple of the line rate. The divisor value to program is four times the reference clock divided by the line rate.

Software drives the port through a small register window and polls flag bits. Each direction has exactly one holding register. Writing the data register queues one character when the transmit side is free. Reading the data register takes the received character. Sticky error bits report a bad stop bit and a lost character. Nothing moves on the line until the enable bit is set.

Register window (bus_addr): 0 = data, 1 = status, 2 = divisor whole part, 3 = control. The status bits are: bit 0 receive-empty, bit 1 transmit-empty, bit 2 framing error, bit 3 overrun. The control bits are: bit 15 enable, bits 5:0 divisor fraction.

Top module: `uartfd_top`

## Requirements
- R1: After reset, txd is high, status reads 0x0003 (receive-empty and transmit-empty set, both error bits clear), and the port is disabled.
- R2: Each tick period is the whole divisor (a value of 0 acts as 1) plus one clock whenever the 6-bit fraction accumulator carries. Any 144 consecutive ticks therefore span 144*W + floor(9*F/4) or 144*W + ceil(9*F/4) clocks, where W is the whole part and F is the fraction.
- R3: txd idles high. A frame is one low start bit, then eight data bits least significant first, then one high stop bit. Each bit lasts 16 ticks, and the start bit begins on a tick.
- R4: A write to address 0 while transmit-empty is 1 stores the character and clears transmit-empty until the transmitter takes it. A write while transmit-empty is 0 is dropped.
- R5: The receiver starts on a falling edge of rxd, confirms the line is still low at the 8th tick, and samples each data bit 16 ticks apart, least significant first. A good frame stores the character and clears receive-empty.
- R6: A read of address 0 returns the stored character and sets receive-empty.
- R7: A stop bit sampled low sets the framing error bit (status bit 2) and discards the character, so receive-empty stays 1.
- R8: A character that completes while one is still waiting sets the overrun bit (status bit 3) and is discarded. The waiting character is kept.
- R9: A read of the status register clears both error bits.
- R10: While enable (control bit 15) is 0, no tick is produced, nothing is sent or received, txd is high, and a queued character waits in the holding register.
- R11: A low pulse on rxd shorter than 8 ticks is rejected: no character is stored and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read of address 0 takes the character) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
Read data is combinational, and a read or write takes effect at the next rising edge, so the bench samples status one cycle after each access. The transmit start bit falls in the clock after a tick, and each tick arrives every W or W+1 clocks. For that reason the 144-tick low time of a zero byte is measured edge by edge and compared with the bounds in R2, and this is swept over all 64 fraction values. Bit centres are probed at 16 + 32k clocks after the falling edge with a whole part of 2 and no fraction. Received characters are polled through the status register and are not expected in a fixed cycle.

// File: rtl/uartfd_pkg.sv
package uartfd_pkg;
  localparam int unsigned INT_W  = 16;
  localparam int unsigned FRAC_W = 6;
  localparam int unsigned OSR    = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BUS_W  = 16;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // Length in clocks of one tick period: whole part (0 acts as 1) plus carry.
  function automatic logic [INT_W:0] tick_len(input logic [INT_W-1:0] whole,
                                              input logic ext);
    logic [INT_W:0] base;
    base = (whole == '0) ? {{INT_W{1'b0}}, 1'b1} : {1'b0, whole};
    return base + {{INT_W{1'b0}}, ext};
  endfunction

  // One step of the fraction accumulator; the top bit is the carry.
  function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] acc,
                                               input logic [FRAC_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction
endpackage

// File: rtl/uartfd_tick.sv
module uartfd_tick
  import uartfd_pkg::*;
#(
  parameter int unsigned IW = INT_W,
  parameter int unsigned FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IW-1:0] div_int,
  input  logic [FW-1:0] div_frac,
  output logic          tick
);
  localparam logic [IW:0] ONE = {{IW{1'b0}}, 1'b1};

  logic [IW:0]   cnt;
  logic [FW-1:0] acc;
  logic          ext;
  logic [IW:0]   len;
  logic [FW:0]   nxt;

  assign len  = tick_len(div_int, ext);
  assign nxt  = frac_step(acc, div_frac);
  assign tick = en && (cnt == len - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
      ext <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      acc <= '0;
      ext <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      acc <= nxt[FW-1:0];
      ext <= nxt[FW];
    end else begin
      cnt <= cnt + ONE;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_int > 1) |=> !tick);
endmodule

// File: rtl/uartfd_tx.sv
module uartfd_tx
  import uartfd_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned OVS = OSR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          hold_valid,
  input  logic [DW-1:0] hold_data,
  output logic          load,
  output logic          busy,
  output logic          txd
);
  localparam int unsigned FRAME_W = DW + 2;
  localparam int unsigned BN_W    = $clog2(FRAME_W);
  localparam int unsigned PH_W    = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [BN_W-1:0] BN_LAST = BN_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [BN_W-1:0]    bitn;
  logic [PH_W-1:0]    phase;

  assign load = en && tick && !busy && hold_valid;
  assign txd  = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      bitn  <= '0;
      phase <= '0;
      busy  <= 1'b0;
    end else if (!en) begin
      shreg <= '1;
      bitn  <= '0;
      phase <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= {1'b1, hold_data, 1'b0};
      bitn  <= '0;
      phase <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        if (bitn == BN_LAST) busy <= 1'b0;
        else                 bitn <= bitn + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uartfd_rx.sv
module uartfd_rx
  import uartfd_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned OVS = OSR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd,
  output logic          done,
  output logic          ferr,
  output logic [DW-1:0] word
);
  localparam int unsigned PH_W = $clog2(OVS);
  localparam int unsigned BN_W = $clog2(DW);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
  localparam logic [BN_W-1:0] BN_LAST = BN_W'(DW - 1);

  logic            s1, s2, s3;
  logic            fall;
  rx_state_e       state;
  logic [PH_W-1:0] phase;
  logic [BN_W-1:0] bitn;
  logic [DW-1:0]   shreg;

  assign fall = s3 && !s2;
  assign word = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      phase <= '0;
      bitn  <= '0;
      shreg <= '0;
      done  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      ferr <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
        phase <= '0;
      end else begin
        case (state)
          RX_IDLE: if (fall) begin
            state <= RX_START;
            phase <= '0;
          end
          RX_START: if (tick) begin
            if (phase == PH_MID) begin
              phase <= '0;
              bitn  <= '0;
              state <= s2 ? RX_IDLE : RX_DATA;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          RX_DATA: if (tick) begin
            if (phase == PH_LAST) begin
              phase <= '0;
              shreg <= {s2, shreg[DW-1:1]};
              if (bitn == BN_LAST) state <= RX_STOP;
              else                 bitn  <= bitn + 1'b1;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          default: if (tick) begin
            if (phase == PH_LAST) begin
              phase <= '0;
              state <= RX_IDLE;
              done  <= s2;
              ferr  <= !s2;
            end else begin
              phase <= phase + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R11
  rx_idle_after_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && tick && phase == PH_MID && s2) |=> (!done && !ferr));
endmodule

// File: rtl/uartfd_top.sv
module uartfd_top
  import uartfd_pkg::*;
#(
  parameter int unsigned IW  = INT_W,
  parameter int unsigned FW  = FRAC_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned BW  = BUS_W,
  parameter int unsigned OVS = OSR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          rxd,
  output logic          txd
);
  logic [IW-1:0] div_int;
  logic [FW-1:0] div_frac;
  logic          en;
  logic [DW-1:0] hold_data;
  logic          hold_valid;
  logic [DW-1:0] rx_data;
  logic          rx_full;
  logic          ferr_f, ovr_f;

  logic          tick, tx_load, tx_busy;
  logic          rx_done, rx_ferr;
  logic [DW-1:0] rx_word;

  logic wr_data, wr_div, wr_ctrl, pop, stat_rd;
  logic tx_empty, rx_empty;

  assign wr_data  = bus_wr && bus_addr == 2'd0;
  assign wr_div   = bus_wr && bus_addr == 2'd2;
  assign wr_ctrl  = bus_wr && bus_addr == 2'd3;
  assign pop      = bus_rd && bus_addr == 2'd0 && rx_full;
  assign stat_rd  = bus_rd && bus_addr == 2'd1;
  assign tx_empty = !hold_valid;
  assign rx_empty = !rx_full;

  uartfd_tick #(.IW(IW), .FW(FW)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en),
    .div_int(div_int), .div_frac(div_frac), .tick(tick)
  );

  uartfd_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .hold_valid(hold_valid), .hold_data(hold_data),
    .load(tx_load), .busy(tx_busy), .txd(txd)
  );

  uartfd_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rxd(rxd),
    .done(rx_done), .ferr(rx_ferr), .word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_int  <= '0;
      div_frac <= '0;
      en       <= 1'b0;
    end else begin
      if (wr_div) div_int <= bus_wdata[IW-1:0];
      if (wr_ctrl) begin
        div_frac <= bus_wdata[FW-1:0];
        en       <= bus_wdata[BW-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data  <= '0;
      hold_valid <= 1'b0;
    end else if (tx_load) begin
      hold_valid <= 1'b0;
    end else if (wr_data && !hold_valid) begin
      hold_data  <= bus_wdata[DW-1:0];
      hold_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      ferr_f  <= 1'b0;
      ovr_f   <= 1'b0;
    end else begin
      if (pop) rx_full <= 1'b0;
      if (rx_done) begin
        if (rx_full && !pop) begin
          ovr_f <= 1'b1;
        end else begin
          rx_data <= rx_word;
          rx_full <= 1'b1;
        end
      end
      if (stat_rd) begin
        ferr_f <= 1'b0;
        if (!(rx_done && rx_full && !pop)) ovr_f <= 1'b0;
      end
      if (rx_ferr) ferr_f <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata[DW-1:0] = rx_data;
      2'd1: bus_rdata[3:0]    = {ovr_f, ferr_f, tx_empty, rx_empty};
      2'd2: bus_rdata[IW-1:0] = div_int;
      default: begin
        bus_rdata[FW-1:0] = div_frac;
        bus_rdata[BW-1]   = en;
      end
    endcase
  end

  // R3
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd) && !$past(tx_busy)) |-> $past(tx_load));
  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && hold_valid) |=> $stable(hold_data));
  // R7
  ferr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ferr && !rx_full) |=> (!rx_full && ferr_f));
  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !pop) |=> ($stable(rx_data) && ovr_f));
  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> txd);
  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_done, rx_ferr}));
endmodule

// File: tb/uartfd_top_test.sv
module uartfd_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        txd, rxd;
  logic        loop_mode = 1'b1;
  logic        drv = 1'b1;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;

  assign rxd = loop_mode ? txd : drv;
  always #10 clk = ~clk;

  uartfd_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_rx(output bit got);
    logic [15:0] st;
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, st);
      if (!st[0]) begin got = 1'b1; break; end
    end
  endtask

  task automatic wait_fall();
    while (txd !== 1'b0) begin @(posedge clk); #1; end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    @(negedge clk);
    drv = 1'b0; repeat (32) @(negedge clk);
    for (int k = 0; k < 8; k++) begin drv = b[k]; repeat (32) @(negedge clk); end
    drv = stop; repeat (32) @(negedge clk);
    drv = 1'b1; repeat (64) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    bit got;
    int cnt, lo, hi;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, v);
    check(v == 16'h0003, "R1 status", v, 3);
    check(txd === 1'b1, "R1 txd idle", txd, 1);

    // R2 R5 R6: sweep every fraction, whole part 2, loopback
    wr(2'd2, 16'd2);
    for (int f = 0; f < 64; f++) begin
      wr(2'd3, 16'h8000 | 16'(f));
      wr(2'd0, 16'h0000);
      wait_fall();
      cnt = 0;
      while (txd !== 1'b1) begin @(posedge clk); #1; cnt++; end
      lo = 288 + (9 * f) / 4;
      hi = lo + (((9 * f) % 4) != 0 ? 1 : 0);
      check(cnt >= lo && cnt <= hi, "R2 low width", cnt, lo);
      wait_rx(got);
      rd(2'd0, v);
      check(got && v[7:0] == 8'h00, "R5 loop zero", v, 0);
      b = 8'(f * 37 + 11);
      wr(2'd0, {8'h00, b});
      wait_rx(got);
      rd(2'd0, v);
      check(got && v[7:0] == b, "R5 loop data", v, b);
      rd(2'd1, v);
      check(v[0] == 1'b1, "R6 empty after read", v[0], 1);
    end

    // R2 whole part 0 acts as 1: zero byte low for exactly 144 clocks
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'd0);
    wr(2'd3, 16'h8000);
    wr(2'd0, 16'h0000);
    wait_fall();
    cnt = 0;
    while (txd !== 1'b1) begin @(posedge clk); #1; cnt++; end
    check(cnt == 144, "R2 whole zero", cnt, 144);
    wait_rx(got);
    rd(2'd0, v);

    // R3 bit centres with whole 2, fraction 0 (32 clocks per bit)
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'd2);
    wr(2'd3, 16'h8000);
    b = 8'hB4;
    wr(2'd0, {8'h00, b});
    wait_fall();
    repeat (16) @(posedge clk);
    #1;
    for (int k = 0; k < 10; k++) begin
      logic e;
      e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      check(txd === e, "R3 frame bit", txd, e);
      repeat (32) @(posedge clk);
      #1;
    end
    wait_rx(got);
    rd(2'd0, v);

    // R10 R4: queue while disabled, second write dropped
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h003C);
    rd(2'd1, v);
    check(v[1] == 1'b0, "R4 tx not empty", v[1], 0);
    wr(2'd0, 16'h00C3);
    repeat (200) @(posedge clk);
    #1 check(txd === 1'b1, "R10 no tx when disabled", txd, 1);
    wr(2'd3, 16'h8000);
    wait_rx(got);
    rd(2'd0, v);
    check(got && v[7:0] == 8'h3C, "R4 dropped write", v, 16'h3C);
    rd(2'd1, v);
    check(v[1] == 1'b1, "R4 tx empty again", v[1], 1);

    // bench-driven receive line
    loop_mode = 1'b0;
    repeat (10) @(negedge clk);

    // R7 framing error, R9 cleared by status read
    send_rx(8'h5A, 1'b0);
    rd(2'd1, v);
    check(v[2] == 1'b1 && v[0] == 1'b1, "R7 ferr and discard", v, 16'h0007);
    rd(2'd1, v);
    check(v[2] == 1'b0, "R9 ferr cleared", v[2], 0);

    // R5 direct receive
    send_rx(8'h96, 1'b1);
    rd(2'd1, v);
    check(v[0] == 1'b0, "R5 rx full", v[0], 0);
    rd(2'd0, v);
    check(v[7:0] == 8'h96, "R5 rx data", v, 16'h96);

    // R8 overrun keeps first character
    send_rx(8'h11, 1'b1);
    send_rx(8'h22, 1'b1);
    rd(2'd1, v);
    check(v[3] == 1'b1, "R8 overrun flag", v[3], 1);
    rd(2'd0, v);
    check(v[7:0] == 8'h11, "R8 first kept", v, 16'h11);
    rd(2'd1, v);
    check(v == 16'h0003, "R9 overrun cleared", v, 3);

    // R11 short low pulse
    @(negedge clk);
    drv = 1'b0; repeat (8) @(negedge clk);
    drv = 1'b1; repeat (400) @(negedge clk);
    rd(2'd1, v);
    check(v == 16'h0003, "R11 glitch rejected", v, 3);

    // R10 receiver idle while disabled
    wr(2'd3, 16'h0000);
    send_rx(8'h77, 1'b1);
    rd(2'd1, v);
    check(v[0] == 1'b1, "R10 no rx when disabled", v[0], 1);

    finish_run();
  end
endmodule